// File: doc/BRIEF.md
# Daisy-Chainable Serial Command Interface for a Dual-Output Power Switch

This block is the serial slave port of a two-channel smart power switch controller. A host lowers the chip-select line, clocks in 8-bit command words MSB first, and raises chip-select again. While a command comes in, the block drives an 8-bit reply out on the serial output. The contents of that reply depend on commands accepted earlier. Once the reply byte is out, the serial output repeats the incoming bits eight bit-times late. Several devices can therefore share one chip-select and be chained output-to-input.

A frame is accepted only if its length is a whole, non-zero number of bytes. In that case the last byte received is decoded and committed. A frame of any other length is dropped completely, as though it had never been sent. All pins are sampled by one system clock through synchronizers. The serial clock is mode 0: input is sampled on the rising edge and output changes on the falling edge. The serial pins are plain level pins: there is no valid/ready stream and no back-pressure, because the host's serial clock sets the pace. Fault and status inputs are plain bit vectors.

Command word layout: bit 7 is the channel select, bits 6..4 are the register address, and bits 3..0 are the payload. Reply layout: bit 7 is always the channel select of the last accepted command. Bits 6..0 depend on the reply-select field.

Top module: `dspi_chain_regif`

## Requirements
- R1: After reset all registers, the reply-select field and the channel-select context are zero. The output `so` is high impedance (`z`) whenever chip-select is high, including after every frame.
- R2: On the falling edge of chip-select, the reply byte is loaded. It is shifted out MSB first, so reply bit 7 is on `so` before the first rising edge of `sclk`, and each falling edge of `sclk` moves the next bit out.
- R3: From the ninth bit of a frame onward, `so` carries the `si` stream delayed by exactly eight bits. The first bit received comes out first.
- R4: On the rising edge of chip-select, a frame is valid only if it held a non-zero multiple of eight bits. Only a valid frame commits, and it commits its last received byte.
- R5: A frame with a bit count of zero or not a multiple of eight changes no register, no reply-select field and no channel-select context. The next reply is the same as if that frame had not been sent.
- R6: Reply bit 7 equals bit 7 of the last accepted command. That bit also picks which channel (0 or 1) the fault and per-channel readbacks and writes refer to.
- R7: With reply-select 000, reply bits 6..0 are the selected channel's fault bits. Fault inputs are sticky: a fault seen at any point since the last chip-select rise is reported, and each chip-select rise reloads the latch from the current fault inputs.
- R8: Address 001 writes payload bit 1 to the selected channel's sense-enable and payload bit 0 to its drive-control bit. Reply-select 001 returns {sense1, drive1, sense0, drive0} in bits 3..0, with bits 6..4 zero.
- R9: Address 010 writes payload bit 3 to the selected channel's overcurrent-high level and payload bits 2..0 to its overcurrent-low level. Reply-select 010 returns the selected channel's high level in bit 3 and its low level in bits 2..0.
- R10: A command to address 111, the reserved test register, changes no register and no reply-select field.
- R11: Address 000 writes payload bits 2..0 into the reply-select field. That field stays in force for every later reply until another address-000 command replaces it. Reply-select 011 returns `dev_stat_i`, and the codes 100 to 111 return zeros in bits 6..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select framing a transfer |
| sclk | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data in, MSB first |
| so | output | 1 | Serial data out, high impedance while deselected |
| fault_i | input | 14 | Fault bits, channel 0 in [6:0], channel 1 in [13:7] |
| dev_stat_i | input | 7 | Device status bits returned for reply-select 011 |
| sense_en_o | output | 2 | Per-channel current-sense enable, bit n for channel n |
| drive_ctl_o | output | 2 | Per-channel serial drive-control bit |
| oc_high_o | output | 2 | Per-channel overcurrent-high level |
| oc_low_o | output | 6 | Per-channel overcurrent-low level, channel 0 in [2:0] |

## Verification
The bench first runs a sequence of one-byte commands that moves through every reply-select code and both channel selects. Each reply is compared with a value worked out from the commands before it. This shows whether the reply follows the stored reply-select field, the channel bit of the previous command, or neither. A two-byte frame separates the status byte from the eight-bit echo, and shows that only the second byte commits. Frames of zero, three and twelve bits, and a short fault pulse, test the cases of discarded frames and sticky fault reporting.

// File: rtl/dspi_pkg.sv
package dspi_pkg;

  localparam int WORD_W  = 8;
  localparam int FAULT_W = 7;
  localparam int N_CH    = 2;

  typedef enum logic [2:0] {
    RA_REPLY_SEL = 3'b000,
    RA_CH_CTL    = 3'b001,
    RA_OC_LVL    = 3'b010,
    RA_DEV_STAT  = 3'b011,
    RA_TEST      = 3'b111
  } reg_addr_e;

  typedef struct packed {
    logic       ch_sel;
    logic [2:0] addr;
    logic [3:0] payload;
  } cmd_t;

endpackage

// File: rtl/dspi_edge_sync.sv
module dspi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sclk_i,
  input  logic si_i,
  output logic cs_low_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic si_o
);

  logic [STAGES-1:0] cs_sh, sclk_sh, si_sh;
  logic              cs_d, sclk_d;
  logic              cs_s, sclk_s;

  assign cs_s = cs_sh[STAGES-1];
  assign sclk_s = sclk_sh[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sh   <= '1;
      sclk_sh <= '0;
      si_sh   <= '0;
      cs_d    <= 1'b1;
      sclk_d  <= 1'b0;
    end else begin
      cs_sh   <= {cs_sh[STAGES-2:0], cs_n_i};
      sclk_sh <= {sclk_sh[STAGES-2:0], sclk_i};
      si_sh   <= {si_sh[STAGES-2:0], si_i};
      cs_d    <= cs_s;
      sclk_d  <= sclk_s;
    end
  end

  assign cs_low_o    = ~cs_s;
  assign cs_fall_o   = cs_d & ~cs_s;
  assign cs_rise_o   = ~cs_d & cs_s;
  assign sclk_rise_o = ~sclk_d & sclk_s;
  assign sclk_fall_o = sclk_d & ~sclk_s;
  assign si_o        = si_sh[STAGES-1];

endmodule

// File: rtl/dspi_shifter.sv
module dspi_shifter
  import dspi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_low_i,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              si_i,
  input  logic [WORD_W-1:0] reply_i,
  output logic              so_d_o,
  output logic              so_oe_o,
  output logic              commit_o,
  output logic [WORD_W-1:0] rx_word_o
);

  localparam int CNT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] tx_q, rx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full_q;
  logic              si_hold_q;
  logic              oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q      <= '0;
      rx_q      <= '0;
      cnt_q     <= '0;
      full_q    <= 1'b0;
      si_hold_q <= 1'b0;
      oe_q      <= 1'b0;
    end else if (cs_fall_i) begin
      tx_q   <= reply_i;
      cnt_q  <= '0;
      full_q <= 1'b0;
      oe_q   <= 1'b1;
    end else if (cs_rise_i) begin
      oe_q <= 1'b0;
    end else if (cs_low_i) begin
      if (sclk_rise_i) begin
        rx_q      <= {rx_q[WORD_W-2:0], si_i};
        si_hold_q <= si_i;
        if (cnt_q == CNT_W'(WORD_W - 1)) begin
          cnt_q  <= '0;
          full_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (sclk_fall_i) tx_q <= {tx_q[WORD_W-2:0], si_hold_q};
    end
  end

  assign so_d_o    = tx_q[WORD_W-1];
  assign so_oe_o   = oe_q;
  assign rx_word_o = rx_q;
  assign commit_o  = cs_rise_i & full_q & (cnt_q == '0);

  // R1: output enable drops after deselect
  assert_so_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_i |=> !oe_q);

  // R2: reply byte parallel-loaded at select
  assert_reply_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall_i |=> (tx_q == $past(reply_i)));

  // R3: after a full byte the outgoing shifter mirrors the receiver
  assert_echo_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_low_i && !cs_rise_i && !cs_fall_i && sclk_fall_i && full_q)
      |=> (tx_q == $past(rx_q)));

endmodule

// File: rtl/dspi_reg_bank.sv
module dspi_reg_bank
  import dspi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [2:0]        reply_sel_o,
  output logic              ch_ctx_o,
  output logic [N_CH-1:0]   sense_en_o,
  output logic [N_CH-1:0]   drive_ctl_o,
  output logic [N_CH-1:0]   oc_high_o,
  output logic [3*N_CH-1:0] oc_low_o
);

  cmd_t              cmd;
  logic [2:0]        reply_sel_q;
  logic              ch_ctx_q;
  logic [N_CH-1:0]   sense_q, drive_q, ochi_q;
  logic [3*N_CH-1:0] oclo_q;

  assign cmd = cmd_t'(word_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reply_sel_q <= '0;
      ch_ctx_q    <= 1'b0;
      sense_q     <= '0;
      drive_q     <= '0;
      ochi_q      <= '0;
      oclo_q      <= '0;
    end else if (commit_i) begin
      ch_ctx_q <= cmd.ch_sel;
      case (reg_addr_e'(cmd.addr))
        RA_REPLY_SEL: reply_sel_q <= cmd.payload[2:0];
        RA_CH_CTL: begin
          sense_q[cmd.ch_sel] <= cmd.payload[1];
          drive_q[cmd.ch_sel] <= cmd.payload[0];
        end
        RA_OC_LVL: begin
          ochi_q[cmd.ch_sel]        <= cmd.payload[3];
          oclo_q[cmd.ch_sel*3 +: 3] <= cmd.payload[2:0];
        end
        default: ;
      endcase
    end
  end

  assign reply_sel_o = reply_sel_q;
  assign ch_ctx_o    = ch_ctx_q;
  assign sense_en_o  = sense_q;
  assign drive_ctl_o = drive_q;
  assign oc_high_o   = ochi_q;
  assign oc_low_o    = oclo_q;

  // R5: nothing moves without a commit
  assert_hold_no_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> ($stable(reply_sel_q) && $stable(ch_ctx_q) && $stable(sense_q)
                   && $stable(drive_q) && $stable(ochi_q) && $stable(oclo_q)));

  // R10: test address leaves every register untouched
  assert_test_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && cmd.addr == RA_TEST) |=> ($stable(reply_sel_q) && $stable(sense_q)
      && $stable(drive_q) && $stable(ochi_q) && $stable(oclo_q)));

endmodule

// File: rtl/dspi_status_mux.sv
module dspi_status_mux
  import dspi_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    release_i,
  input  logic [N_CH*FAULT_W-1:0] fault_i,
  input  logic [FAULT_W-1:0]      dev_stat_i,
  input  logic [2:0]              reply_sel_i,
  input  logic                    ch_ctx_i,
  input  logic [N_CH-1:0]         sense_en_i,
  input  logic [N_CH-1:0]         drive_ctl_i,
  input  logic [N_CH-1:0]         oc_high_i,
  input  logic [3*N_CH-1:0]       oc_low_i,
  output logic [WORD_W-1:0]       reply_o
);

  logic [N_CH*FAULT_W-1:0] flt_q;
  logic [FAULT_W-1:0]      body;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flt_q <= '0;
    else if (release_i) flt_q <= fault_i;
    else                flt_q <= flt_q | fault_i;
  end

  always_comb begin
    body = '0;
    case (reg_addr_e'(reply_sel_i))
      RA_REPLY_SEL: body = flt_q[ch_ctx_i*FAULT_W +: FAULT_W];
      RA_CH_CTL:    body[3:0] = {sense_en_i[1], drive_ctl_i[1],
                                 sense_en_i[0], drive_ctl_i[0]};
      RA_OC_LVL:    body[3:0] = {oc_high_i[ch_ctx_i], oc_low_i[ch_ctx_i*3 +: 3]};
      RA_DEV_STAT:  body = dev_stat_i;
      default:      body = '0;
    endcase
  end

  assign reply_o = {ch_ctx_i, body};

  // R7: latched faults never drop between releases
  assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !release_i |=> ((flt_q & $past(flt_q)) == $past(flt_q)));

endmodule

// File: rtl/dspi_chain_regif.sv
module dspi_chain_regif
  import dspi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    sclk,
  input  logic                    si,
  output logic                    so,
  input  logic [N_CH*FAULT_W-1:0] fault_i,
  input  logic [FAULT_W-1:0]      dev_stat_i,
  output logic [N_CH-1:0]         sense_en_o,
  output logic [N_CH-1:0]         drive_ctl_o,
  output logic [N_CH-1:0]         oc_high_o,
  output logic [3*N_CH-1:0]       oc_low_o
);

  logic              cs_low, cs_fall, cs_rise, sclk_rise, sclk_fall, si_s;
  logic              so_d, so_oe, commit;
  logic [WORD_W-1:0] rx_word, reply;
  logic [2:0]        reply_sel;
  logic              ch_ctx;

  dspi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .si_i(si),
    .cs_low_o(cs_low), .cs_fall_o(cs_fall), .cs_rise_o(cs_rise),
    .sclk_rise_o(sclk_rise), .sclk_fall_o(sclk_fall), .si_o(si_s)
  );

  dspi_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .cs_low_i(cs_low), .cs_fall_i(cs_fall),
    .cs_rise_i(cs_rise), .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .si_i(si_s), .reply_i(reply), .so_d_o(so_d), .so_oe_o(so_oe),
    .commit_o(commit), .rx_word_o(rx_word)
  );

  dspi_reg_bank u_regs (
    .clk(clk), .rst_n(rst_n), .commit_i(commit), .word_i(rx_word),
    .reply_sel_o(reply_sel), .ch_ctx_o(ch_ctx), .sense_en_o(sense_en_o),
    .drive_ctl_o(drive_ctl_o), .oc_high_o(oc_high_o), .oc_low_o(oc_low_o)
  );

  dspi_status_mux u_stat (
    .clk(clk), .rst_n(rst_n), .release_i(cs_rise), .fault_i(fault_i),
    .dev_stat_i(dev_stat_i), .reply_sel_i(reply_sel), .ch_ctx_i(ch_ctx),
    .sense_en_i(sense_en_o), .drive_ctl_i(drive_ctl_o), .oc_high_i(oc_high_o),
    .oc_low_i(oc_low_o), .reply_o(reply)
  );

  assign so = so_oe ? so_d : 1'bz;

  // R4: a commit only happens at deselect
  assert_commit_at_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> cs_rise);

endmodule

// File: tb/tb_dspi_chain_regif.sv
module tb_dspi_chain_regif;

  localparam int HALF = 10;
  localparam int NV   = 11;
  // {command word, expected reply}
  localparam logic [15:0] VEC [NV] = '{
    16'h00_15, 16'h83_15, 16'h1B_B3, 16'hA9_33, 16'h81_B3, 16'h92_83,
    16'h02_8B, 16'hF5_00, 16'h80_89, 16'h00_AA, 16'h42_15
  };

  logic        clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, si = 1'b0;
  wire         so;
  logic [13:0] fault_i = {7'h2A, 7'h15};
  logic [6:0]  dev_stat_i = 7'h33;
  logic [1:0]  sense_en_o, drive_ctl_o, oc_high_o;
  logic [5:0]  oc_low_o;
  int          total = 0, bad = 0;
  logic        done = 1'b0;
  logic [15:0] got;

  always #2 clk = ~clk;

  dspi_chain_regif dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si), .so(so),
    .fault_i(fault_i), .dev_stat_i(dev_stat_i), .sense_en_o(sense_en_o),
    .drive_ctl_o(drive_ctl_o), .oc_high_o(oc_high_o), .oc_low_o(oc_low_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] data, input int nbits, output logic [15:0] rx);
    rx = '0;
    cs_n = 1'b0;
    waitc(HALF);
    for (int i = 0; i < nbits; i++) begin
      si = data[nbits-1-i];
      waitc(HALF);
      rx = {rx[14:0], so};
      sclk = 1'b1;
      waitc(HALF);
      sclk = 1'b0;
    end
    waitc(HALF);
    cs_n = 1'b1;
    waitc(3 * HALF);
  endtask

  initial begin
    waitc(5);
    rst_n = 1'b1;
    waitc(5);
    // R1: reset state
    check("R1 so idle", {31'd0, so === 1'bz}, 32'd1);
    check("R1 regs zero", {18'd0, sense_en_o, drive_ctl_o, oc_high_o, oc_low_o}, 32'd0);

    // R2 R6 R7 R8 R9 R10 R11: one-byte command walk
    for (int k = 0; k < NV; k++) begin
      xfer({8'h00, VEC[k][15:8]}, 8, got);
      check($sformatf("R2/R6/R11 reply step %0d", k), {24'd0, got[7:0]}, {24'd0, VEC[k][7:0]});
    end
    check("R1 so idle after frame", {31'd0, so === 1'bz}, 32'd1);
    check("R8 sense_en", {30'd0, sense_en_o}, 32'd3);
    check("R8 drive_ctl", {30'd0, drive_ctl_o}, 32'd1);
    check("R9 oc_high", {30'd0, oc_high_o}, 32'd2);
    check("R9 oc_low", {26'd0, oc_low_o}, 32'h08);

    // R3 R4: two-byte frame, echo and last-byte commit
    xfer(16'h519D, 16, got);
    check("R2 first byte status", {24'd0, got[15:8]}, 32'h15);
    check("R3 echo of first byte", {24'd0, got[7:0]}, 32'h51);
    check("R4 last byte commit sense", {30'd0, sense_en_o}, 32'd1);
    check("R4 last byte commit drive", {30'd0, drive_ctl_o}, 32'd3);

    // R5: invalid frames of 0, 3 and 12 bits
    xfer(16'h0000, 0, got);
    xfer(16'h0000, 3, got);
    xfer(16'h0FA2, 12, got);
    check("R5 oc_high unchanged", {30'd0, oc_high_o}, 32'd2);
    check("R5 oc_low unchanged", {26'd0, oc_low_o}, 32'h08);
    xfer(16'h0000, 8, got);
    check("R5 reply ignores bad frames", {24'd0, got[7:0]}, 32'hAA);

    // R7: sticky fault pulse, released at chip-select rise
    fault_i[6:0] = 7'h55;
    waitc(5);
    fault_i[6:0] = 7'h15;
    waitc(5);
    xfer(16'h0000, 8, got);
    check("R7 sticky fault seen", {24'd0, got[7:0]}, 32'h55);
    xfer(16'h0000, 8, got);
    check("R7 fault released", {24'd0, got[7:0]}, 32'h15);

    // R10: test address write with payload, reply-select must stay 0
    xfer(16'h0077, 8, got);
    xfer(16'h0000, 8, got);
    check("R10 test write ignored", {24'd0, got[7:0]}, 32'h15);
    check("R10 regs unchanged", {18'd0, sense_en_o, drive_ctl_o, oc_high_o, oc_low_o},
          {18'd0, 2'b01, 2'b11, 2'b10, 6'h08});

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule